// File: doc/BRIEF.md
# Uncached Request Bridge: TileLink-UL Upstream, AXI4 Downstream

This block sits between an agent that issues single-beat TileLink Uncached Lightweight requests and a memory-mapped AXI4 slave. It accepts one request on the A channel and replays it as one AXI4 write (an address and a data beat) or one AXI4 read. It then waits for the write or read response and answers on the D channel. The D answer carries the requester's source tag, so the agent can match it to its request.

Only one transaction is in flight at a time. While a request is being served, the A channel is closed. The write address and write data channels are raised together, and each one completes its own handshake. The source tag travels to the AXI ID, and the TileLink size code travels to the AXI size field unchanged. Any A opcode other than the two put forms and get is answered locally with an error, and no AXI traffic is produced.

Top module: `tlul_axi_bridge`

## Requirements
- R1: Opcode decoding. A-channel opcode 0 (full put) and 1 (partial put) produce an AXI write. Opcode 4 (get) produces an AXI read. D-channel opcode 0 acknowledges a write, and opcode 1 returns read data.
- R2: For a put, awaddr, awid and awsize equal the accepted address, source and size. wdata and wstrb equal the accepted data and mask. awlen is 0, awburst is 2'b01 (incrementing) and wlast is 1.
- R3: For a get, araddr, arid and arsize equal the accepted address, source and size, arlen is 0 and arburst is 2'b01. The A mask and data of a get have no effect on any AXI output.
- R4: awvalid and wvalid rise together in the cycle after a put is accepted. Each one drops in the cycle after its own handshake. While its ready is low it stays high, even when the other channel has already completed.
- R5: A B-channel handshake produces a D response with opcode 0 and d_source equal to the original request source, whatever bid carries.
- R6: An R-channel handshake produces a D response with opcode 1, d_data equal to rdata, and d_source equal to the original request source.
- R7: d_error is 0 when the AXI response code is 0 (OKAY) or 1. It is 1 when the code is 2 or 3 (slave or decode error).
- R8: Once d_valid is high, it stays high with unchanged opcode, source, data and error until d_ready is sampled high. It drops in the following cycle.
- R9: a_ready is high only when the bridge is idle. It is low from the acceptance of a request until the cycle after that request's D handshake, and it is never high while any AXI or D valid is high.
- R10: An A request with any other opcode raises no AXI valid. It is answered in the cycle after acceptance with D opcode 0 and d_error 1.
- R11: While rst_n is low, every valid output is low. After reset, a_ready is high and no partially completed write handshake is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Request valid |
| a_ready | output | 1 | Request accepted when high with a_valid |
| a_opcode | input | 3 | Request opcode |
| a_param | input | 3 | Request parameter, unused |
| a_size | input | 3 | log2 of request byte count |
| a_source | input | IDW | Requester tag |
| a_address | input | AW | Byte address |
| a_mask | input | DW/8 | Byte enables |
| a_data | input | DW | Write data |
| d_valid | output | 1 | Response valid |
| d_ready | input | 1 | Response taken |
| d_opcode | output | 3 | Response opcode |
| d_source | output | IDW | Tag of the request being answered |
| d_data | output | DW | Read data |
| d_error | output | 1 | Response carries an error |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awid | output | IDW | Write ID |
| awaddr | output | AW | Write address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DW | Write data |
| wstrb | output | DW/8 | Write strobes |
| wlast | output | 1 | Last write beat |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bid | input | IDW | Write response ID |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| arid | output | IDW | Read ID |
| araddr | output | AW | Read address |
| arlen | output | 8 | Beats minus one |
| arsize | output | 3 | Beat size code |
| arburst | output | 2 | Burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rid | input | IDW | Read ID |
| rdata | input | DW | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat |

## Verification
A wrong pending flag in the write tracker shows up in the cycle after a one-sided handshake. Either the completed channel repeats its valid, or the stalled one drops it. In both cases the bridge may then wait forever for a write response that is never requested. A wrong sequencer state shows up within one cycle as an early a_ready, a ready offered on the wrong response channel, or a D response that appears without a handshake. A fault in the response holder shows up as a wrong opcode, error bit or data word on the first D beat after a B or R handshake, or as a value that changes while d_ready is held low.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam logic [2:0] A_OP_PUT_FULL = 3'd0;
  localparam logic [2:0] A_OP_PUT_PART = 3'd1;
  localparam logic [2:0] A_OP_GET      = 3'd4;

  localparam logic [2:0] D_OP_ACK      = 3'd0;
  localparam logic [2:0] D_OP_ACK_DATA = 3'd1;

  localparam logic [1:0] BURST_INCR    = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ISSUE,
    ST_WR_RESP,
    ST_RD_ISSUE,
    ST_RD_RESP,
    ST_D_OUT
  } tlb_state_e;

  typedef enum logic [1:0] {
    KIND_WRITE,
    KIND_READ,
    KIND_BAD
  } req_kind_e;

  function automatic req_kind_e classify(input logic [2:0] op);
    if (op == A_OP_PUT_FULL || op == A_OP_PUT_PART) return KIND_WRITE;
    if (op == A_OP_GET) return KIND_READ;
    return KIND_BAD;
  endfunction

  // slave error and decode error both have the upper code bit set
  function automatic logic resp_is_err(input logic [1:0] resp);
    return resp[1];
  endfunction

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_fire,
  input  req_kind_e  a_kind,
  input  logic       wr_issue_done,
  input  logic       ar_fire,
  input  logic       b_fire,
  input  logic       r_fire,
  input  logic       d_fire,
  output tlb_state_e state_q
);

  tlb_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (a_fire) begin
        unique case (a_kind)
          KIND_WRITE: state_d = ST_WR_ISSUE;
          KIND_READ:  state_d = ST_RD_ISSUE;
          default:    state_d = ST_D_OUT;
        endcase
      end
      ST_WR_ISSUE: if (wr_issue_done) state_d = ST_WR_RESP;
      ST_WR_RESP:  if (b_fire)        state_d = ST_D_OUT;
      ST_RD_ISSUE: if (ar_fire)       state_d = ST_RD_RESP;
      ST_RD_RESP:  if (r_fire)        state_d = ST_D_OUT;
      ST_D_OUT:    if (d_fire)        state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tlb_wr_track.sv
module tlb_wr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic awready,
  input  logic wready,
  output logic aw_pend_q,
  output logic w_pend_q,
  output logic all_done
);

  logic aw_left, w_left, aw_pend_d, w_pend_d, en;

  assign aw_left   = aw_pend_q & ~awready;
  assign w_left    = w_pend_q & ~wready;
  assign all_done  = ~aw_left & ~w_left;
  assign aw_pend_d = start | aw_left;
  assign w_pend_d  = start | w_left;
  assign en        = start | aw_pend_q | w_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
    end else if (en) begin
      aw_pend_q <= aw_pend_d;
      w_pend_q  <= w_pend_d;
    end
  end

endmodule

// File: rtl/tlb_d_hold.sv
module tlb_d_hold #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    op_in,
  input  logic          err_in,
  input  logic [DW-1:0] data_in,
  output logic [2:0]    op_q,
  output logic          err_q,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      op_q   <= op_in;
      err_q  <= err_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/tlul_axi_bridge.sv
module tlul_axi_bridge
  import tlb_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 6,
  parameter int DW  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_valid,
  output logic            a_ready,
  input  logic [2:0]      a_opcode,
  input  logic [2:0]      a_param,
  input  logic [2:0]      a_size,
  input  logic [IDW-1:0]  a_source,
  input  logic [AW-1:0]   a_address,
  input  logic [DW/8-1:0] a_mask,
  input  logic [DW-1:0]   a_data,
  output logic            d_valid,
  input  logic            d_ready,
  output logic [2:0]      d_opcode,
  output logic [IDW-1:0]  d_source,
  output logic [DW-1:0]   d_data,
  output logic            d_error,
  output logic            awvalid,
  input  logic            awready,
  output logic [IDW-1:0]  awid,
  output logic [AW-1:0]   awaddr,
  output logic [7:0]      awlen,
  output logic [2:0]      awsize,
  output logic [1:0]      awburst,
  output logic            wvalid,
  input  logic            wready,
  output logic [DW-1:0]   wdata,
  output logic [DW/8-1:0] wstrb,
  output logic            wlast,
  input  logic            bvalid,
  output logic            bready,
  input  logic [IDW-1:0]  bid,
  input  logic [1:0]      bresp,
  output logic            arvalid,
  input  logic            arready,
  output logic [IDW-1:0]  arid,
  output logic [AW-1:0]   araddr,
  output logic [7:0]      arlen,
  output logic [2:0]      arsize,
  output logic [1:0]      arburst,
  input  logic            rvalid,
  output logic            rready,
  input  logic [IDW-1:0]  rid,
  input  logic [DW-1:0]   rdata,
  input  logic [1:0]      rresp,
  input  logic            rlast
);

  localparam int SW = DW / 8;

  tlb_state_e state_q;
  req_kind_e  a_kind;
  logic       a_fire, ar_fire, b_fire, r_fire, d_fire;
  logic       wr_start, wr_done, aw_pend, w_pend;
  logic       d_load, d_err_in;
  logic [2:0] d_op_in;
  logic [DW-1:0] d_data_in;

  logic [AW-1:0]  req_addr_q;
  logic [IDW-1:0] req_id_q;
  logic [2:0]     req_size_q;
  logic [SW-1:0]  req_strb_q;
  logic [DW-1:0]  req_data_q;

  // param, bid, rid and rlast carry nothing needed by a single in-flight beat
  logic unused_in;
  assign unused_in = ^{a_param, bid, rid, rlast};

  assign a_kind  = classify(a_opcode);
  assign a_ready = (state_q == ST_IDLE);
  assign a_fire  = a_valid & a_ready;
  assign ar_fire = arvalid & arready;
  assign b_fire  = bvalid & bready;
  assign r_fire  = rvalid & rready;
  assign d_fire  = d_valid & d_ready;
  assign wr_start = a_fire & (a_kind == KIND_WRITE);

  // request capture: address side for every request, data side for puts only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q <= '0;
      req_id_q   <= '0;
      req_size_q <= '0;
    end else if (a_fire) begin
      req_addr_q <= a_address;
      req_id_q   <= a_source;
      req_size_q <= a_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_strb_q <= '0;
      req_data_q <= '0;
    end else if (wr_start) begin
      req_strb_q <= a_mask;
      req_data_q <= a_data;
    end
  end

  tlb_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .a_fire        (a_fire),
    .a_kind        (a_kind),
    .wr_issue_done (wr_done),
    .ar_fire       (ar_fire),
    .b_fire        (b_fire),
    .r_fire        (r_fire),
    .d_fire        (d_fire),
    .state_q       (state_q)
  );

  tlb_wr_track wr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (wr_start),
    .awready   (awready),
    .wready    (wready),
    .aw_pend_q (aw_pend),
    .w_pend_q  (w_pend),
    .all_done  (wr_done)
  );

  always_comb begin
    d_load    = 1'b0;
    d_op_in   = D_OP_ACK;
    d_err_in  = 1'b0;
    d_data_in = '0;
    if (b_fire) begin
      d_load   = 1'b1;
      d_err_in = resp_is_err(bresp);
    end else if (r_fire) begin
      d_load    = 1'b1;
      d_op_in   = D_OP_ACK_DATA;
      d_err_in  = resp_is_err(rresp);
      d_data_in = rdata;
    end else if (a_fire && a_kind == KIND_BAD) begin
      d_load   = 1'b1;
      d_err_in = 1'b1;
    end
  end

  tlb_d_hold #(.DW(DW)) dh_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (d_load),
    .op_in   (d_op_in),
    .err_in  (d_err_in),
    .data_in (d_data_in),
    .op_q    (d_opcode),
    .err_q   (d_error),
    .data_q  (d_data)
  );

  assign d_valid  = (state_q == ST_D_OUT);
  assign d_source = req_id_q;

  assign awvalid = aw_pend;
  assign awid    = req_id_q;
  assign awaddr  = req_addr_q;
  assign awlen   = 8'd0;
  assign awsize  = req_size_q;
  assign awburst = BURST_INCR;
  assign wvalid  = w_pend;
  assign wdata   = req_data_q;
  assign wstrb   = req_strb_q;
  assign wlast   = 1'b1;
  assign bready  = (state_q == ST_WR_RESP);

  assign arvalid = (state_q == ST_RD_ISSUE);
  assign arid    = req_id_q;
  assign araddr  = req_addr_q;
  assign arlen   = 8'd0;
  assign arsize  = req_size_q;
  assign arburst = BURST_INCR;
  assign rready  = (state_q == ST_RD_RESP);

endmodule

// File: rtl/tlb_bridge_chk.sv
module tlb_bridge_chk #(
  parameter int IDW = 6,
  parameter int DW  = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           a_valid,
  input logic           a_ready,
  input logic [2:0]     a_opcode,
  input logic           d_valid,
  input logic           d_ready,
  input logic [2:0]     d_opcode,
  input logic [IDW-1:0] d_source,
  input logic [DW-1:0]  d_data,
  input logic           d_error,
  input logic           awvalid,
  input logic           awready,
  input logic           wvalid,
  input logic           wready,
  input logic           bvalid,
  input logic           bready,
  input logic [1:0]     bresp,
  input logic           arvalid,
  input logic           rvalid,
  input logic           rready,
  input logic [DW-1:0]  rdata
);

  AST_GET_TO_AR: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_ready && a_opcode == 3'd4 |=> arvalid && !awvalid && !wvalid); // R1

  AST_PUT_TO_AW_W: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_ready && a_opcode == 3'd0 |=> awvalid && wvalid && !arvalid); // R4

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid); // R4

  AST_W_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && wready |=> !wvalid); // R4

  AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rready |=> d_valid && d_opcode == 3'd1 && d_data == $past(rdata)); // R6

  AST_OKAY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && bready && bresp == 2'd0 |=> d_valid && !d_error); // R7

  AST_D_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_source) && $stable(d_opcode) && $stable(d_error)); // R8

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    a_ready |-> !awvalid && !wvalid && !arvalid && !d_valid); // R9

  AST_BAD_OP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_ready && a_opcode == 3'd2 |=> d_valid && d_error && !awvalid && !arvalid); // R10

endmodule

bind tlul_axi_bridge tlb_bridge_chk #(.IDW(IDW), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_valid  (a_valid),
  .a_ready  (a_ready),
  .a_opcode (a_opcode),
  .d_valid  (d_valid),
  .d_ready  (d_ready),
  .d_opcode (d_opcode),
  .d_source (d_source),
  .d_data   (d_data),
  .d_error  (d_error),
  .awvalid  (awvalid),
  .awready  (awready),
  .wvalid   (wvalid),
  .wready   (wready),
  .bvalid   (bvalid),
  .bready   (bready),
  .bresp    (bresp),
  .arvalid  (arvalid),
  .rvalid   (rvalid),
  .rready   (rready),
  .rdata    (rdata)
);

// File: tb/tlul_axi_bridge_tb_top.sv
module tlul_axi_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int IDW = 6;
  localparam int DW  = 256;
  localparam int SW  = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic a_valid, a_ready;
  logic [2:0] a_opcode, a_param, a_size;
  logic [IDW-1:0] a_source;
  logic [AW-1:0] a_address;
  logic [SW-1:0] a_mask;
  logic [DW-1:0] a_data;
  logic d_valid, d_ready, d_error;
  logic [2:0] d_opcode;
  logic [IDW-1:0] d_source;
  logic [DW-1:0] d_data;
  logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [IDW-1:0] awid, bid, arid, rid;
  logic [AW-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst, bresp, rresp;
  logic [DW-1:0] wdata, rdata;
  logic [SW-1:0] wstrb;
  logic arvalid, arready, rvalid, rready, rlast;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlul_axi_bridge #(.AW(AW), .IDW(IDW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode), .a_param(a_param),
    .a_size(a_size), .a_source(a_source), .a_address(a_address), .a_mask(a_mask),
    .a_data(a_data),
    .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode), .d_source(d_source),
    .d_data(d_data), .d_error(d_error),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] pat(input logic [31:0] s);
    return {8{s}};
  endfunction

  task automatic idle_inputs();
    a_valid = 0; a_opcode = 0; a_param = 0; a_size = 0; a_source = 0;
    a_address = 0; a_mask = 0; a_data = 0; d_ready = 0;
    awready = 0; wready = 0; bvalid = 0; bid = 0; bresp = 0;
    arready = 0; rvalid = 0; rid = 0; rdata = 0; rresp = 0; rlast = 0;
  endtask

  task automatic send_a(input logic [2:0] op, input logic [AW-1:0] addr,
                        input logic [IDW-1:0] src, input logic [2:0] sz,
                        input logic [SW-1:0] m, input logic [DW-1:0] dat);
    a_valid = 1; a_opcode = op; a_address = addr; a_source = src;
    a_size = sz; a_mask = m; a_data = dat;
    while (!a_ready) tick();
    tick();
    a_valid = 0;
  endtask

  task automatic take_d(input string req);
    d_ready = 1;
    tick();
    d_ready = 0;
    chk(!d_valid, req, d_valid, 0);
    chk(a_ready, req, a_ready, 1);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    #(CLK_PERIOD*2);
    chk(!awvalid && !wvalid && !arvalid && !d_valid, "R11",
        {awvalid, wvalid, arvalid, d_valid}, 0);
    @(negedge clk);
    rst_n = 1;
    tick();
    chk(a_ready, "R11", a_ready, 1);
  endtask

  task automatic t_put_basic();
    send_a(3'd0, 32'h1000_0040, 6'd17, 3'd5, '1, pat(32'hA5A5_0001));
    chk(awvalid && wvalid && !arvalid, "R1", {awvalid, wvalid, arvalid}, 3'b110);
    chk(awvalid && wvalid, "R4", {awvalid, wvalid}, 2'b11);
    chk(awaddr == 32'h1000_0040, "R2", awaddr, 32'h1000_0040);
    chk(awid == 6'd17 && awsize == 3'd5, "R2", {awid, awsize}, {6'd17, 3'd5});
    chk(wdata == pat(32'hA5A5_0001), "R2", wdata, pat(32'hA5A5_0001));
    chk(wstrb == '1 && wlast && awlen == 0 && awburst == 2'b01, "R2",
        {wstrb == '1, wlast, awlen, awburst}, {1'b1, 1'b1, 8'd0, 2'b01});
    chk(!a_ready, "R9", a_ready, 0);
    awready = 1; wready = 1;
    tick();
    awready = 0; wready = 0;
    chk(!awvalid && !wvalid && bready, "R4", {awvalid, wvalid, bready}, 3'b001);
    bvalid = 1; bresp = 2'd0; bid = 6'd3;
    tick();
    bvalid = 0;
    chk(d_valid && d_opcode == 3'd0, "R5", {d_valid, d_opcode}, {1'b1, 3'd0});
    chk(d_source == 6'd17, "R5", d_source, 6'd17);
    chk(!d_error, "R7", d_error, 0);
    tick(); tick();
    chk(d_valid && d_source == 6'd17 && d_opcode == 3'd0, "R8",
        {d_valid, d_source}, {1'b1, 6'd17});
    chk(!a_ready, "R9", a_ready, 0);
    take_d("R9");
  endtask

  task automatic t_put_split();
    send_a(3'd1, 32'h2000_0008, 6'd42, 3'd2, 32'h0000_00F0, pat(32'h1234_5678));
    awready = 0; wready = 1;
    tick();
    wready = 0;
    chk(awvalid && !wvalid, "R4", {awvalid, wvalid}, 2'b10);
    tick(); tick();
    chk(awvalid && !wvalid && !bready, "R4", {awvalid, wvalid, bready}, 3'b100);
    chk(wstrb == 32'h0000_00F0, "R2", wstrb, 32'h0000_00F0);
    awready = 1;
    tick();
    awready = 0;
    chk(!awvalid && bready, "R4", {awvalid, bready}, 2'b01);
    bvalid = 1; bresp = 2'd2;
    tick();
    bvalid = 0;
    chk(d_valid && d_error && d_source == 6'd42, "R7", {d_error, d_source}, {1'b1, 6'd42});
    take_d("R8");
    // address channel first, data channel later
    send_a(3'd0, 32'h2000_0100, 6'd5, 3'd3, 32'h0000_FF00, pat(32'h0BAD_CAFE));
    awready = 1;
    tick();
    awready = 0;
    chk(!awvalid && wvalid, "R4", {awvalid, wvalid}, 2'b01);
    wready = 1;
    tick();
    wready = 0;
    chk(!wvalid && bready, "R4", {wvalid, bready}, 2'b01);
    bvalid = 1; bresp = 2'd3;
    tick();
    bvalid = 0;
    chk(d_error, "R7", d_error, 1);
    take_d("R9");
  endtask

  task automatic t_get(input logic [1:0] code, input logic [31:0] seed);
    send_a(3'd4, 32'h3000_0020, 6'd9, 3'd4, 32'hDEAD_BEEF, pat(32'h7777_7777));
    chk(arvalid && !awvalid && !wvalid, "R1", {arvalid, awvalid, wvalid}, 3'b100);
    chk(araddr == 32'h3000_0020 && arid == 6'd9 && arsize == 3'd4, "R3",
        {araddr, arid, arsize}, {32'h3000_0020, 6'd9, 3'd4});
    chk(arlen == 0 && arburst == 2'b01, "R3", {arlen, arburst}, {8'd0, 2'b01});
    // mask and data of a get must leave the write-side outputs untouched
    chk(wstrb == 32'h0000_FF00 && wdata == pat(32'h0BAD_CAFE), "R3", wdata, pat(32'h0BAD_CAFE));
    a_valid = 1; a_opcode = 3'd0;
    chk(!a_ready, "R9", a_ready, 0);
    arready = 1;
    tick();
    arready = 0;
    chk(!arvalid && rready, "R3", {arvalid, rready}, 2'b01);
    rvalid = 1; rdata = pat(seed); rresp = code; rid = 6'd1; rlast = 1;
    tick();
    rvalid = 0; rdata = 0;
    chk(d_valid && d_opcode == 3'd1 && d_source == 6'd9, "R6",
        {d_valid, d_opcode, d_source}, {1'b1, 3'd1, 6'd9});
    chk(d_data == pat(seed), "R6", d_data, pat(seed));
    chk(d_error == code[1], "R7", d_error, code[1]);
    a_valid = 0;
    take_d("R8");
    chk(!awvalid && !arvalid, "R9", {awvalid, arvalid}, 0);
  endtask

  task automatic t_bad_op();
    send_a(3'd2, 32'h4000_0000, 6'd33, 3'd0, '1, pat(32'h1));
    chk(!awvalid && !wvalid && !arvalid, "R10", {awvalid, wvalid, arvalid}, 0);
    chk(d_valid && d_opcode == 3'd0 && d_error && d_source == 6'd33, "R10",
        {d_valid, d_opcode, d_error, d_source}, {1'b1, 3'd0, 1'b1, 6'd33});
    take_d("R10");
  endtask

  task automatic t_reset_mid();
    send_a(3'd0, 32'h5000_0000, 6'd2, 3'd1, 32'h3, pat(32'h5));
    wready = 1;
    tick();
    wready = 0;
    chk(awvalid && !wvalid, "R4", {awvalid, wvalid}, 2'b10);
    do_reset();
    chk(!awvalid && !wvalid, "R11", {awvalid, wvalid}, 0);
    send_a(3'd0, 32'h5000_0010, 6'd4, 3'd1, 32'h3, pat(32'h6));
    chk(awvalid && wvalid, "R11", {awvalid, wvalid}, 2'b11);
    awready = 1; wready = 1;
    tick();
    awready = 0; wready = 0;
    bvalid = 1; bresp = 0;
    tick();
    bvalid = 0;
    take_d("R11");
  endtask

  initial begin
    do_reset();
    t_put_basic();
    t_put_split();
    t_get(2'd0, 32'hC0DE_0001);
    t_get(2'd1, 32'hC0DE_0002);
    t_get(2'd3, 32'hC0DE_0003);
    t_bad_op();
    t_reset_mid();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule